// File: doc/BRIEF.md
# Indirect Control/Status Register Port for a Network Controller

This block is the host-facing register window of a network controller. The host sees only two locations. The first is a selector port. A write to it picks which of four internal control/status registers the second port, the data port, will reach. The selector keeps its value until the host writes it again. A host driver writes the selector once and then issues any number of data-port accesses to the chosen register.

Register 0 is the command and status word. Writing its command bits stops the controller, starts initialization, starts transmit and receive, or asks for an immediate transmit descriptor poll. Its event flags are cleared by writing a one to them. Registers 1 and 2 hold the low and high parts of the initialization block address. Register 3 holds bus-control settings. These three registers take writes only while the controller is stopped.

Initialization is handed to an external engine through a request/done handshake, and the engine reports either success or failure. An interrupt output summarises the pending event flags, gated by the interrupt enable. Host requests use a valid/ready handshake. A read produces a response beat on a second valid/ready channel. A response that has not been consumed holds the request channel off, so at most one read is ever outstanding.

Top module: `lctl_csr_port`

## Requirements
- R1: A write on the selector port (`req_sel_addr`=1) stores `req_wdata[1:0]` as the selection: 0 = command/status, 1 = address low, 2 = address high, 3 = bus control. The selection persists across any number of data-port accesses. A read of the selector port returns the selection in bits 1:0 with all other bits zero.
- R2: Register 1 holds `init_addr[15:0]` (all 16 bits). Register 2 holds `init_addr[ADDR_W-1:16]` in its low bits and reads zero above them. Register 3 holds `bus_ctl` in its low BCTL_W bits and reads zero above them. Both outputs reflect the stored values one cycle after the accepted write.
- R3: After reset the controller is stopped, register 0 reads 0x0004 and registers 1–3 read zero. A data-port write to registers 1–3 is ignored whenever the controller is not stopped.
- R4: Register 0 bit layout: 15 ERR, 14 BABL, 13 CERR, 12 MISS, 11 MERR, 10 RINT, 9 TINT, 8 IDON, 7 INTR, 6 INEA, 5 RXON, 4 TXON, 3 TDMD, 2 STOP, 1 STRT, 0 INIT. Writing STOP (bit 2) enters the stopped state and clears RXON, TXON, INEA, all event flags (bits 14:8) and any pending initialization. STOP overrides STRT and INIT written in the same word.
- R5: Writing INIT (bit 0) without STOP leaves the stopped state and raises `init_req`. `init_req` stays high until `init_done` or `init_fail` is seen. Done sets IDON. Failure sets MERR. Bit 0 reads 1 while the request is pending.
- R6: Event flags (bits 14:8) are cleared by writing 1 in their position, and writing 0 leaves them unchanged. An event arriving in the same cycle as a clear of the same flag leaves the flag set.
- R7: INTR (bit 7) reads 1 when any of BABL, MISS, MERR, RINT, TINT or IDON is set; CERR does not count. `irq` is high exactly when INTR and INEA are both set.
- R8: ERR (bit 15) reads 1 when any of BABL, CERR, MISS or MERR is set.
- R9: Writing STRT (bit 1) without STOP leaves the stopped state and sets RXON and TXON (`rx_on`, `tx_on` high). STRT reads 1 while running. INEA (bit 6) takes the written value on every register 0 write that does not carry STOP.
- R10: Writing TDMD (bit 3) without STOP, while running or together with STRT, makes `poll_pulse` high for exactly the one cycle after the accepted write. When the controller is not running, no pulse is produced. TDMD always reads 0.
- R11: While stopped, the event inputs `ev_rx`, `ev_tx`, `ev_babble`, `ev_miss`, `ev_merr` and `ev_cerr` leave every flag unchanged. When not stopped, they set RINT, TINT, BABL, MISS, MERR and CERR respectively.
- R12: A request is accepted on a cycle with `req_valid` and `req_ready` both high, and `req_ready` = !`rsp_valid` | `rsp_ready`. An accepted read raises `rsp_valid` on the next cycle with the register contents sampled at acceptance. `rsp_valid` and `rsp_rdata` hold steady while `rsp_ready` is low, and a request offered while `req_ready` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_sel_addr | input | 1 | 1 = selector port, 0 = data port |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 16 | Read response data |
| init_req | output | 1 | Initialization request to the external engine |
| init_done | input | 1 | Engine finished initialization |
| init_fail | input | 1 | Engine failed initialization |
| init_addr | output | ADDR_W | Initialization block address |
| bus_ctl | output | BCTL_W | Bus-control settings |
| ev_rx | input | 1 | Receive completion event |
| ev_tx | input | 1 | Transmit completion event |
| ev_babble | input | 1 | Transmitter babble event |
| ev_miss | input | 1 | Missed frame event |
| ev_merr | input | 1 | Memory error event |
| ev_cerr | input | 1 | Collision heartbeat error event |
| rx_on | output | 1 | Receiver enabled |
| tx_on | output | 1 | Transmitter enabled |
| poll_pulse | output | 1 | One-cycle transmit descriptor poll request |
| irq | output | 1 | Summary interrupt, active high |

## Verification
A corrupted selection shows up on the very next data-port access, because reads then return another register and writes land in the wrong place. A run flag or flag vector that is out of step with the model shows on `rx_on`/`tx_on`/`irq` one cycle after the offending write or event, and on the next read of register 0. A lost init request is visible on `init_req` in the cycle after the INIT write. A wrong configuration lock shows on `init_addr` or `bus_ctl` one cycle after a write made while running.

// File: rtl/lctl_pkg.sv
`timescale 1ns/1ps
package lctl_pkg;
  // command/status word bit positions (host software decodes these)
  localparam int unsigned B_INIT    = 0;
  localparam int unsigned B_STRT    = 1;
  localparam int unsigned B_STOP    = 2;
  localparam int unsigned B_TDMD    = 3;
  localparam int unsigned B_TXON    = 4;
  localparam int unsigned B_RXON    = 5;
  localparam int unsigned B_INEA    = 6;
  localparam int unsigned B_INTR    = 7;
  localparam int unsigned B_FLAG_LO = 8;
  localparam int unsigned B_ERR     = 15;

  // event flags, contiguous from B_FLAG_LO
  localparam int unsigned N_FLAGS = 7;
  localparam int unsigned F_IDON  = 0;
  localparam int unsigned F_TINT  = 1;
  localparam int unsigned F_RINT  = 2;
  localparam int unsigned F_MERR  = 3;
  localparam int unsigned F_MISS  = 4;
  localparam int unsigned F_CERR  = 5;
  localparam int unsigned F_BABL  = 6;

  // flags that raise INTR (all but the heartbeat error)
  localparam logic [N_FLAGS-1:0] INT_SRC_MASK = 7'b101_1111;
  // flags that form ERR (BABL, CERR, MISS, MERR)
  localparam logic [N_FLAGS-1:0] ERR_SRC_MASK = 7'b111_1000;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_ADR_LO = 2'd1,
    SEL_ADR_HI = 2'd2,
    SEL_BUS    = 2'd3
  } csr_sel_e;
endpackage

// File: rtl/lctl_sel.sv
`timescale 1ns/1ps
module lctl_sel
  import lctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wsel,
  output csr_sel_e   sel
);
  always_ff @(posedge clk) begin
    if (!rst_n)     sel <= SEL_CTRL;
    else if (wr_en) sel <= csr_sel_e'(wsel);
  end

  // R1: selection only moves on a selector-port write
  p_sel_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(sel));
endmodule

// File: rtl/lctl_cfg.sv
`timescale 1ns/1ps
module lctl_cfg
  import lctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned BCTL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  csr_sel_e          sel,
  input  logic [15:0]       wdata,
  input  logic              stopped,
  output logic [ADDR_W-1:0] init_addr,
  output logic [BCTL_W-1:0] bus_ctl,
  output logic [15:0]       rd_data
);
  localparam int unsigned HI_W = ADDR_W - 16;

  logic [15:0]       lo_q;
  logic [HI_W-1:0]   hi_q;
  logic [BCTL_W-1:0] bc_q;
  logic              load;

  assign load = wr_en && stopped;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
      bc_q <= '0;
    end else if (load) begin
      case (sel)
        SEL_ADR_LO: lo_q <= wdata;
        SEL_ADR_HI: hi_q <= wdata[HI_W-1:0];
        SEL_BUS:    bc_q <= wdata[BCTL_W-1:0];
        default:    ;
      endcase
    end
  end

  assign init_addr = {hi_q, lo_q};
  assign bus_ctl   = bc_q;

  always_comb begin
    case (sel)
      SEL_ADR_LO: rd_data = lo_q;
      SEL_ADR_HI: rd_data = 16'(hi_q);
      SEL_BUS:    rd_data = 16'(bc_q);
      default:    rd_data = '0;
    endcase
  end

  // R3: configuration is frozen while the controller is not stopped
  p_cfg_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !stopped |=> ($stable(lo_q) && $stable(hi_q) && $stable(bc_q)));
endmodule

// File: rtl/lctl_ctrl.sv
`timescale 1ns/1ps
module lctl_ctrl
  import lctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wdata,
  input  logic        ev_rx,
  input  logic        ev_tx,
  input  logic        ev_babble,
  input  logic        ev_miss,
  input  logic        ev_merr,
  input  logic        ev_cerr,
  input  logic        init_done,
  input  logic        init_fail,
  output logic [15:0] csr0,
  output logic        stopped,
  output logic        running,
  output logic        init_req,
  output logic        poll_pulse,
  output logic        irq
);
  logic               stopped_q, run_q, inea_q, pend_q, poll_q;
  logic [N_FLAGS-1:0] flags, set_vec, clr_vec;
  logic               cmd_stop, cmd_init, cmd_strt, cmd_poll, live;
  logic               intr, err;
  logic               unused_wbits;

  assign unused_wbits = ^{wdata[B_ERR], wdata[B_INTR], wdata[B_RXON], wdata[B_TXON]};

  assign cmd_stop = wr_en && wdata[B_STOP];
  assign cmd_init = wr_en && wdata[B_INIT] && !cmd_stop;
  assign cmd_strt = wr_en && wdata[B_STRT] && !cmd_stop;
  assign cmd_poll = wr_en && wdata[B_TDMD] && !cmd_stop && (run_q || cmd_strt);
  assign live     = !stopped_q;

  always_comb begin
    set_vec         = '0;
    set_vec[F_IDON] = pend_q && init_done;
    set_vec[F_TINT] = live && ev_tx;
    set_vec[F_RINT] = live && ev_rx;
    set_vec[F_MERR] = (live && ev_merr) || (pend_q && init_fail);
    set_vec[F_MISS] = live && ev_miss;
    set_vec[F_CERR] = live && ev_cerr;
    set_vec[F_BABL] = live && ev_babble;
  end

  assign clr_vec = wr_en ? wdata[B_FLAG_LO +: N_FLAGS] : '0;

  // one write-one-to-clear cell per event flag; a new event beats a clear
  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n)          q <= 1'b0;
      else if (cmd_stop)   q <= 1'b0;
      else if (set_vec[g]) q <= 1'b1;
      else if (clr_vec[g]) q <= 1'b0;
    end
    assign flags[g] = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stopped_q <= 1'b1;
      run_q     <= 1'b0;
      inea_q    <= 1'b0;
      pend_q    <= 1'b0;
      poll_q    <= 1'b0;
    end else begin
      poll_q <= cmd_poll;
      if (cmd_stop) begin
        stopped_q <= 1'b1;
        run_q     <= 1'b0;
        inea_q    <= 1'b0;
        pend_q    <= 1'b0;
      end else begin
        if (wr_en) inea_q <= wdata[B_INEA];
        if (cmd_init || cmd_strt) stopped_q <= 1'b0;
        if (cmd_strt) run_q <= 1'b1;
        if (cmd_init) pend_q <= 1'b1;
        else if (init_done || init_fail) pend_q <= 1'b0;
      end
    end
  end

  assign intr = |(flags & INT_SRC_MASK);
  assign err  = |(flags & ERR_SRC_MASK);

  always_comb begin
    csr0                           = '0;
    csr0[B_ERR]                    = err;
    csr0[B_FLAG_LO +: N_FLAGS]     = flags;
    csr0[B_INTR]                   = intr;
    csr0[B_INEA]                   = inea_q;
    csr0[B_RXON]                   = run_q;
    csr0[B_TXON]                   = run_q;
    csr0[B_STOP]                   = stopped_q;
    csr0[B_STRT]                   = run_q;
    csr0[B_INIT]                   = pend_q;
  end

  assign stopped    = stopped_q;
  assign running    = run_q;
  assign init_req   = pend_q;
  assign poll_pulse = poll_q;
  assign irq        = intr && inea_q;

  // R4: stop overrides everything written alongside it
  p_stop_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |=> (stopped_q && !run_q && !pend_q && !inea_q && flags == '0));

  // R6: flags move only on an event or a host write
  p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && set_vec == '0) |=> flags == $past(flags));

  // R11: a stopped controller keeps its flags through events
  p_stopped_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped_q && !wr_en) |=> flags == $past(flags));

  // R5: the init request holds until the engine answers
  p_init_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !init_done && !init_fail && !wr_en) |=> pend_q);

  // R10: a poll pulse always follows a host write
  p_poll_after_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    poll_q |-> $past(wr_en));
endmodule

// File: rtl/lctl_csr_port.sv
`timescale 1ns/1ps
module lctl_csr_port
  import lctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned BCTL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_sel_addr,
  input  logic              req_write,
  input  logic [15:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [15:0]       rsp_rdata,
  output logic              init_req,
  input  logic              init_done,
  input  logic              init_fail,
  output logic [ADDR_W-1:0] init_addr,
  output logic [BCTL_W-1:0] bus_ctl,
  input  logic              ev_rx,
  input  logic              ev_tx,
  input  logic              ev_babble,
  input  logic              ev_miss,
  input  logic              ev_merr,
  input  logic              ev_cerr,
  output logic              rx_on,
  output logic              tx_on,
  output logic              poll_pulse,
  output logic              irq
);
  csr_sel_e    sel;
  logic        acc, sel_wr, data_wr, ctrl_wr, cfg_wr, rd_acc;
  logic        stopped, running;
  logic [15:0] csr0, cfg_rd, rd_mux;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign sel_wr    = acc && req_write && req_sel_addr;
  assign data_wr   = acc && req_write && !req_sel_addr;
  assign ctrl_wr   = data_wr && (sel == SEL_CTRL);
  assign cfg_wr    = data_wr && (sel != SEL_CTRL);
  assign rd_acc    = acc && !req_write;

  lctl_sel u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (sel_wr),
    .wsel  (req_wdata[1:0]),
    .sel   (sel)
  );

  lctl_cfg #(.ADDR_W(ADDR_W), .BCTL_W(BCTL_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr),
    .sel       (sel),
    .wdata     (req_wdata),
    .stopped   (stopped),
    .init_addr (init_addr),
    .bus_ctl   (bus_ctl),
    .rd_data   (cfg_rd)
  );

  lctl_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (ctrl_wr),
    .wdata      (req_wdata),
    .ev_rx      (ev_rx),
    .ev_tx      (ev_tx),
    .ev_babble  (ev_babble),
    .ev_miss    (ev_miss),
    .ev_merr    (ev_merr),
    .ev_cerr    (ev_cerr),
    .init_done  (init_done),
    .init_fail  (init_fail),
    .csr0       (csr0),
    .stopped    (stopped),
    .running    (running),
    .init_req   (init_req),
    .poll_pulse (poll_pulse),
    .irq        (irq)
  );

  assign rx_on = running;
  assign tx_on = running;

  always_comb begin
    if (req_sel_addr)          rd_mux = {14'd0, sel};
    else if (sel == SEL_CTRL)  rd_mux = csr0;
    else                       rd_mux = cfg_rd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (rd_acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R12: an unconsumed response stays put
  p_rsp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

// File: tb/lctl_csr_port_tb.sv
`timescale 1ns/1ps
module lctl_csr_port_tb;
  localparam int ADDR_W = 24;
  localparam int BCTL_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_sel_addr = 0, req_write = 0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_ready = 1'b1;
  logic [15:0] rsp_rdata;
  logic init_req, init_done = 0, init_fail = 0;
  logic [ADDR_W-1:0] init_addr;
  logic [BCTL_W-1:0] bus_ctl;
  logic ev_rx = 0, ev_tx = 0, ev_babble = 0, ev_miss = 0, ev_merr = 0, ev_cerr = 0;
  logic rx_on, tx_on, poll_pulse, irq;

  always #4 clk = ~clk;

  lctl_csr_port #(.ADDR_W(ADDR_W), .BCTL_W(BCTL_W)) u_dut (.*);

  int n_chk = 0, n_fail = 0;

  // reference model, built from the requirements
  logic       m_stopped = 1, m_run = 0, m_inea = 0, m_pend = 0, m_poll = 0;
  logic [6:0] m_flags = '0; // 0 IDON 1 TINT 2 RINT 3 MERR 4 MISS 5 CERR 6 BABL
  logic [1:0] m_rap = 0;
  logic [15:0] m_lo = 0;
  logic [7:0]  m_hi = 0;
  logic [2:0]  m_bc = 0;

  function automatic logic m_intr();
    return |(m_flags & 7'b101_1111);
  endfunction

  function automatic logic [15:0] exp_csr0();
    logic [15:0] v = '0;
    v[15]   = |m_flags[6:3];
    v[14:8] = m_flags;
    v[7]    = m_intr();
    v[6]    = m_inea;
    v[5]    = m_run;
    v[4]    = m_run;
    v[2]    = m_stopped;
    v[1]    = m_run;
    v[0]    = m_pend;
    return v;
  endfunction

  function automatic logic [15:0] exp_data();
    case (m_rap)
      2'd0: return exp_csr0();
      2'd1: return m_lo;
      2'd2: return {8'd0, m_hi};
      default: return {13'd0, m_bc};
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_wr0(input logic [15:0] d);
    m_poll = 0;
    if (d[2]) begin
      m_stopped = 1; m_run = 0; m_inea = 0; m_pend = 0; m_flags = '0;
    end else begin
      m_flags = m_flags & ~d[14:8];
      m_inea  = d[6];
      m_poll  = d[3] && (m_run || d[1]);
      if (d[0]) begin m_pend = 1; m_stopped = 0; end
      if (d[1]) begin m_run = 1; m_stopped = 0; end
    end
  endtask

  task automatic model_wr(input logic aport, input logic [15:0] d);
    m_poll = 0;
    if (aport) m_rap = d[1:0];
    else if (m_rap == 2'd0) model_wr0(d);
    else if (m_stopped) begin
      if (m_rap == 2'd1) m_lo = d;
      else if (m_rap == 2'd2) m_hi = d[7:0];
      else m_bc = d[2:0];
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pins(input string tag);
    check({tag, " R7 irq"}, irq, m_intr() && m_inea);
    check({tag, " R5 init_req"}, init_req, m_pend);
    check({tag, " R9 rx_on"}, rx_on, m_run);
    check({tag, " R9 tx_on"}, tx_on, m_run);
    check({tag, " R10 poll_pulse"}, poll_pulse, m_poll);
    check({tag, " R2 init_addr"}, init_addr, {m_hi, m_lo});
    check({tag, " R2 bus_ctl"}, bus_ctl, m_bc);
  endtask

  task automatic host_wr(input logic aport, input logic [15:0] d);
    req_valid = 1; req_write = 1; req_sel_addr = aport; req_wdata = d;
    model_wr(aport, d);
    step();
    req_valid = 0; req_write = 0;
  endtask

  task automatic host_rd(input string tag, input logic aport);
    logic [15:0] e;
    e = aport ? {14'd0, m_rap} : exp_data();
    m_poll = 0;
    req_valid = 1; req_write = 0; req_sel_addr = aport;
    step();
    req_valid = 0;
    check({tag, " R12 rsp_valid"}, rsp_valid, 1'b1);
    check(tag, rsp_rdata, e);
  endtask

  task automatic event_pulse(input int k);
    m_poll = 0;
    case (k)
      0: ev_rx = 1;
      1: ev_tx = 1;
      2: ev_babble = 1;
      3: ev_miss = 1;
      4: ev_merr = 1;
      default: ev_cerr = 1;
    endcase
    if (!m_stopped) begin
      case (k)
        0: m_flags[2] = 1;
        1: m_flags[1] = 1;
        2: m_flags[6] = 1;
        3: m_flags[4] = 1;
        4: m_flags[3] = 1;
        default: m_flags[5] = 1;
      endcase
    end
    step();
    {ev_rx, ev_tx, ev_babble, ev_miss, ev_merr, ev_cerr} = '0;
  endtask

  task automatic init_answer(input logic ok);
    m_poll = 0;
    if (ok) init_done = 1; else init_fail = 1;
    if (m_pend) begin
      if (ok) m_flags[0] = 1; else m_flags[3] = 1;
      m_pend = 0;
    end
    step();
    init_done = 0; init_fail = 0;
  endtask

  logic finished = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R3 reset state
    check("R3 reset req_ready", req_ready, 1'b1);
    pins("R3 reset");
    host_rd("R3 reset csr0", 1'b0);
    host_wr(1'b1, 16'h0002);
    host_rd("R1 selector readback", 1'b1);
    host_rd("R3 reset addr-high", 1'b0);
    host_rd("R1 selector persists", 1'b1);

    // R2 configuration load while stopped
    host_wr(1'b1, 16'h0001); host_wr(1'b0, 16'hBEEF);
    host_wr(1'b1, 16'h0002); host_wr(1'b0, 16'h12AB);
    host_wr(1'b1, 16'hFFFB); host_wr(1'b0, 16'h0005);
    pins("R2 config");
    check("R2 init_addr value", init_addr, 24'hABBEEF);
    check("R2 bus_ctl value", bus_ctl, 3'd5);
    host_rd("R2 bus readback", 1'b0);

    // R5 init request
    host_wr(1'b1, 16'h0000);
    host_wr(1'b0, 16'h0041);
    pins("R5 init issued");
    host_rd("R5 csr0 pending", 1'b0);
    check("R5 pending value", exp_csr0(), 16'h0041);
    host_wr(1'b1, 16'h0001); host_wr(1'b0, 16'h1111);
    pins("R3 locked write");
    host_rd("R3 locked readback", 1'b0);
    host_wr(1'b1, 16'h0000);
    init_answer(1'b1);
    pins("R5 init done");
    host_rd("R5 idon csr0", 1'b0);
    check("R7 idon irq", irq, 1'b1);

    // R6 write-one-to-clear
    host_wr(1'b0, 16'h0040);
    host_rd("R6 zero keeps idon", 1'b0);
    host_wr(1'b0, 16'h0140);
    pins("R6 idon cleared");
    host_rd("R6 cleared csr0", 1'b0);

    // R9 start, R10 poll
    host_wr(1'b0, 16'h0042);
    pins("R9 started");
    host_rd("R9 csr0 running", 1'b0);
    host_wr(1'b0, 16'h0048);
    pins("R10 poll");
    check("R10 poll high", poll_pulse, 1'b1);
    host_rd("R10 tdmd reads 0", 1'b0);
    check("R10 poll one cycle", poll_pulse, 1'b0);

    // R8 error summary, R7 CERR is no interrupt source
    event_pulse(5);
    host_rd("R8 cerr err", 1'b0);
    check("R7 cerr no irq", irq, 1'b0);
    event_pulse(3);
    pins("R7 miss irq");
    host_rd("R8 miss err", 1'b0);

    // R6 set beats clear in the same cycle
    ev_miss = 1;
    host_wr(1'b0, 16'h1040);
    ev_miss = 0;
    m_flags[4] = 1;
    host_rd("R6 set wins", 1'b0);

    // R4 stop priority
    host_wr(1'b0, 16'h0047);
    pins("R4 stop");
    host_rd("R4 stop csr0", 1'b0);
    check("R4 stop value", exp_csr0(), 16'h0004);

    // R11 events ignored while stopped
    event_pulse(0);
    event_pulse(4);
    pins("R11 stopped");
    host_rd("R11 flags unchanged", 1'b0);

    // R5 init failure
    host_wr(1'b0, 16'h0001);
    init_answer(1'b0);
    pins("R5 init fail");
    host_rd("R5 fail sets merr", 1'b0);

    // R10 no poll when not running
    host_wr(1'b0, 16'h0008);
    check("R10 no poll idle", poll_pulse, 1'b0);

    // R12 back-pressure
    rsp_ready = 0;
    req_valid = 1; req_write = 0; req_sel_addr = 0;
    step();
    check("R12 rsp valid", rsp_valid, 1'b1);
    check("R12 rsp data", rsp_rdata, exp_csr0());
    check("R12 ready low", req_ready, 1'b0);
    req_write = 1; req_sel_addr = 1; req_wdata = 16'h0003;
    step();
    check("R12 held valid", rsp_valid, 1'b1);
    check("R12 held data", rsp_rdata, exp_csr0());
    req_valid = 0; req_write = 0;
    rsp_ready = 1;
    step();
    check("R12 drained", rsp_valid, 1'b0);
    host_rd("R12 blocked write ignored", 1'b1);

    // random phase
    for (int i = 0; i < 600; i++) begin
      int unsigned r;
      logic [15:0] d;
      r = $urandom % 10;
      d = 16'($urandom);
      if (r < 2) host_wr(1'b1, d);
      else if (r < 5) begin
        if ($urandom % 4 != 0) d[2] = 1'b0;
        host_wr(1'b0, d);
      end
      else if (r < 7) host_rd("R1 R6 random data read", 1'b0);
      else if (r == 7) host_rd("R1 random selector read", 1'b1);
      else if (r == 8) event_pulse(int'($urandom % 6));
      else if (m_pend) init_answer(1'($urandom % 2));
      else host_rd("R4 random csr read", 1'b0);
      pins("R12 random");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule